// File: doc/BRIEF.md
# Dual-Channel Tri-State Phase Detector with Lock Qualifier

This block sits after the reference and feedback dividers of two frequency-synthesis loops. It runs on the oscillator clock. For each channel it takes a reference pulse `fr` and a divided-feedback pulse `fp`, both synchronous to that clock. It drives two pump-control bits, `up` and `dn`, to the charge pump. Both bits low means the pump is off (high impedance). A per-channel polarity bit swaps the meaning of `up` and `dn`, so that the sense can match the slope of the oscillator's tuning curve. The number of clock cycles between the two edges of a comparison is the phase error. A lock qualifier reads that error and decides whether the channel is locked.

Each channel contains two state machines. The edge tracker has four states. `PD_IDLE` waits for an edge. If `fr` arrives alone it goes to `PD_RLEAD`. If `fp` arrives alone it goes to `PD_PLEAD`. If both arrive in the same cycle it goes to `PD_ALIGN`. From `PD_RLEAD` an `fp` edge leads to `PD_ALIGN`, and from `PD_PLEAD` an `fr` edge leads to `PD_ALIGN`. `PD_ALIGN` lasts one cycle with both pump bits high; it then behaves like `PD_IDLE`. The lock qualifier has two states, `LK_HUNT` and `LK_HELD`. It moves from hunt to held when a run of good comparisons is complete. It moves from held to hunt when one comparison has a large error. A power-save input per channel parks both machines in their idle states. One output pin, `mon_o`, carries either the combined lock flag or one of the four incoming pulse trains, chosen for test.

Top module: `pdl_top`

## Requirements
- R1: With the polarity bit at 1, an `fr` edge that arrives before the `fp` edge sets `up`=1, `dn`=0. This holds from the cycle after the `fr` edge until the `fp` edge is sampled. With the polarity bit at 0, the same case sets `up`=0, `dn`=1.
- R2: With the polarity bit at 1, an `fp` edge that arrives first sets `up`=0, `dn`=1 for the same span. With the polarity bit at 0, it sets `up`=1, `dn`=0.
- R3: An edge that closes a comparison raises both `up` and `dn` for exactly one cycle. So do `fr` and `fp` edges that arrive in the same cycle. After that cycle both bits are 0 unless a new edge has arrived.
- R4: The phase error is the number of clock cycles between the opening edge and the closing edge. It is 0 for coincident edges and saturates at 2^CNT_W−1. An error of UNLOCK_WIN (8) or more clears the channel's lock one cycle after the closing edge is sampled.
- R5: A channel becomes locked only on the LOCK_RUN-th (3rd) consecutive comparison whose error is at most LOCK_WIN (4). An error from 5 to 7 restarts the run but leaves a held lock in place.
- R6: While a channel's `sleep_i` bit is 1, its `up` and `dn` are 0 and the channel counts as locked. Its trackers and lock history are cleared, so after wake-up it reports unlocked until a new run qualifies.
- R7: With `lds_i`=0, `mon_o` is 1 only when every channel is locked or asleep.
- R8: With `lds_i`=1, `mon_o` is combinational from the inputs. `tsel_i[0]` picks the channel (0 = channel 0, 1 = channel 1). `tsel_i[1]` picks the signal (0 = `fr`, 1 = `fp`).
- R9: After reset all pump bits are 0 and both channels are unlocked, so `mon_o`=0 with `lds_i`=0 and neither channel asleep.
- R10: A second edge of the leading signal, arriving before the other signal's edge, is ignored. The lead state holds and the error count keeps running from the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fr_i | input | 2 | Reference pulse, one bit per channel |
| fp_i | input | 2 | Divided-feedback pulse, one bit per channel |
| pol_i | input | 2 | Pump polarity per channel |
| sleep_i | input | 2 | Power save per channel, active high |
| lds_i | input | 1 | 0: lock flag on `mon_o`; 1: test monitor |
| tsel_i | input | 2 | Monitor select: bit 0 channel, bit 1 fr/fp |
| pump_up_o | output | 2 | Pump-up control per channel |
| pump_dn_o | output | 2 | Pump-down control per channel |
| mon_o | output | 1 | Combined lock flag or monitored pulse |

## Verification
Each channel is swept over offsets from −10 to +10 cycles under both polarities, with the other channel asleep. Negative and positive offsets tell the two lead states apart. Zero offset exercises the coincidence path. The descending-then-rising error sequence crosses the unlock boundary at 8, the neutral band from 5 to 7, and the three-in-a-row rule at 4 or less. A directed run sends a repeated `fr` edge after lock. The measured error is 9 when the count runs from the first edge and 4 if it restarted, so the lock result tells the two behaviours apart. All four monitor selects are tried against all sixteen input patterns.

// File: rtl/pdl_pkg.sv
package pdl_pkg;

    localparam int unsigned NCH = 2;

    typedef enum logic [1:0] {
        PD_IDLE,
        PD_RLEAD,
        PD_PLEAD,
        PD_ALIGN
    } pd_state_t;

    typedef enum logic {
        LK_HUNT,
        LK_HELD
    } lk_state_t;

endpackage

// File: rtl/pdl_tracker.sv
module pdl_tracker
    import pdl_pkg::*;
#(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep,
    input  logic             fr,
    input  logic             fp,
    input  logic             pol,
    output logic             up,
    output logic             dn,
    output logic             done,
    output logic [CNT_W-1:0] err
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    pd_state_t        state, nxt;
    logic             fr_q, fp_q;
    logic             fr_e, fp_e;
    logic [CNT_W-1:0] cnt;
    logic             lead_r, lead_p;

    assign fr_e = fr & ~fr_q;
    assign fp_e = fp & ~fp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q <= 1'b0;
            fp_q <= 1'b0;
        end else begin
            fr_q <= fr;
            fp_q <= fp;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     state <= PD_IDLE;
        else if (sleep) state <= PD_IDLE;
        else            state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            PD_IDLE, PD_ALIGN: begin
                if (fr_e && fp_e) nxt = PD_ALIGN;
                else if (fr_e)    nxt = PD_RLEAD;
                else if (fp_e)    nxt = PD_PLEAD;
                else              nxt = PD_IDLE;
            end
            PD_RLEAD: if (fp_e) nxt = PD_ALIGN;
            PD_PLEAD: if (fr_e) nxt = PD_ALIGN;
        endcase
    end

    // error counter and completion strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            done <= 1'b0;
            err  <= '0;
        end else if (sleep) begin
            cnt  <= '0;
            done <= 1'b0;
            err  <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                PD_IDLE, PD_ALIGN: begin
                    if (fr_e && fp_e) begin
                        done <= 1'b1;
                        err  <= '0;
                        cnt  <= '0;
                    end else if (fr_e || fp_e) begin
                        cnt <= CNT_W'(1);
                    end
                end
                PD_RLEAD, PD_PLEAD: begin
                    if ((state == PD_RLEAD && fp_e) || (state == PD_PLEAD && fr_e)) begin
                        done <= 1'b1;
                        err  <= cnt;
                        cnt  <= '0;
                    end else if (cnt != CNT_MAX) begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        lead_r = 1'b0;
        lead_p = 1'b0;
        unique case (state)
            PD_IDLE:  ;
            PD_RLEAD: lead_r = 1'b1;
            PD_PLEAD: lead_p = 1'b1;
            PD_ALIGN: begin
                lead_r = 1'b1;
                lead_p = 1'b1;
            end
        endcase
        up = ~sleep & (pol ? lead_r : lead_p);
        dn = ~sleep & (pol ? lead_p : lead_r);
    end

endmodule

// File: rtl/pdl_lockq.sv
module pdl_lockq
    import pdl_pkg::*;
#(
    parameter int unsigned CNT_W      = 6,
    parameter int unsigned LOCK_WIN   = 4,
    parameter int unsigned UNLOCK_WIN = 8,
    parameter int unsigned LOCK_RUN   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep,
    input  logic             done,
    input  logic [CNT_W-1:0] err,
    output logic             held
);

    localparam int unsigned      RUN_W   = $clog2(LOCK_RUN + 1);
    localparam logic [CNT_W-1:0] LW      = CNT_W'(LOCK_WIN);
    localparam logic [CNT_W-1:0] UW      = CNT_W'(UNLOCK_WIN);
    localparam logic [RUN_W-1:0] RUN_END = RUN_W'(LOCK_RUN - 1);

    lk_state_t        state, nxt;
    logic [RUN_W-1:0] run, run_nxt;
    logic             good, bad;

    assign good = done && (err <= LW);
    assign bad  = done && (err >= UW);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= LK_HUNT;
            run   <= '0;
        end else if (sleep) begin
            state <= LK_HUNT;
            run   <= '0;
        end else begin
            state <= nxt;
            run   <= run_nxt;
        end
    end

    // transitions
    always_comb begin
        nxt     = state;
        run_nxt = run;
        unique case (state)
            LK_HUNT: begin
                if (good) begin
                    if (run == RUN_END) begin
                        nxt     = LK_HELD;
                        run_nxt = '0;
                    end else begin
                        run_nxt = run + RUN_W'(1);
                    end
                end else if (done) begin
                    run_nxt = '0;
                end
            end
            LK_HELD: begin
                if (bad) begin
                    nxt     = LK_HUNT;
                    run_nxt = '0;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        unique case (state)
            LK_HUNT: held = 1'b0;
            LK_HELD: held = 1'b1;
        endcase
    end

endmodule

// File: rtl/pdl_top.sv
module pdl_top
    import pdl_pkg::*;
#(
    parameter int unsigned CNT_W      = 6,
    parameter int unsigned LOCK_WIN   = 4,
    parameter int unsigned UNLOCK_WIN = 8,
    parameter int unsigned LOCK_RUN   = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] fr_i,
    input  logic [NCH-1:0] fp_i,
    input  logic [NCH-1:0] pol_i,
    input  logic [NCH-1:0] sleep_i,
    input  logic           lds_i,
    input  logic [1:0]     tsel_i,
    output logic [NCH-1:0] pump_up_o,
    output logic [NCH-1:0] pump_dn_o,
    output logic           mon_o
);

    logic [NCH-1:0]            done_w;
    logic [NCH-1:0][CNT_W-1:0] err_w;
    logic [NCH-1:0]            held_w;
    logic [NCH-1:0]            lock_rep;
    logic                      mon_sel;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pdl_tracker #(.CNT_W(CNT_W)) u_trk (
            .clk   (clk),
            .rst_n (rst_n),
            .sleep (sleep_i[g]),
            .fr    (fr_i[g]),
            .fp    (fp_i[g]),
            .pol   (pol_i[g]),
            .up    (pump_up_o[g]),
            .dn    (pump_dn_o[g]),
            .done  (done_w[g]),
            .err   (err_w[g])
        );

        pdl_lockq #(
            .CNT_W      (CNT_W),
            .LOCK_WIN   (LOCK_WIN),
            .UNLOCK_WIN (UNLOCK_WIN),
            .LOCK_RUN   (LOCK_RUN)
        ) u_lk (
            .clk   (clk),
            .rst_n (rst_n),
            .sleep (sleep_i[g]),
            .done  (done_w[g]),
            .err   (err_w[g]),
            .held  (held_w[g])
        );

        assign lock_rep[g] = held_w[g] | sleep_i[g];
    end

    assign mon_sel = tsel_i[1] ? fp_i[tsel_i[0]] : fr_i[tsel_i[0]];
    assign mon_o   = lds_i ? mon_sel : (&lock_rep);

endmodule

// File: rtl/pdl_chk.sv
module pdl_chk
    import pdl_pkg::*;
#(
    parameter int unsigned CNT_W      = 6,
    parameter int unsigned LOCK_WIN   = 4,
    parameter int unsigned UNLOCK_WIN = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NCH-1:0]            fr,
    input logic [NCH-1:0]            fp,
    input logic [NCH-1:0]            sleep,
    input logic [NCH-1:0]            up,
    input logic [NCH-1:0]            dn,
    input logic [NCH-1:0]            done,
    input logic [NCH-1:0][CNT_W-1:0] err,
    input logic [NCH-1:0]            lock,
    input logic                      lds,
    input logic [1:0]                tsel,
    input logic                      mon
);

    for (genvar g = 0; g < NCH; g++) begin : g_a
        AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            sleep[g] |-> (!up[g] && !dn[g])); // R6

        AST_ALIGN_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
            (up[g] && dn[g]) |=> !(up[g] && dn[g])); // R3

        AST_LOCK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
            (done[g] && err[g] >= CNT_W'(UNLOCK_WIN) && !sleep[g]) |=> !lock[g]); // R4

        AST_LOCK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(lock[g]) |-> $past(done[g] && err[g] <= CNT_W'(LOCK_WIN))); // R5
    end

    AST_MON_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!lds && !sleep[0] && !lock[0]) |-> !mon); // R7

    AST_MON_FR0: assert property (@(posedge clk) disable iff (!rst_n)
        (lds && tsel == 2'b00) |-> (mon == fr[0])); // R8

    AST_MON_FP1: assert property (@(posedge clk) disable iff (!rst_n)
        (lds && tsel == 2'b11) |-> (mon == fp[1])); // R8

endmodule

bind pdl_top pdl_chk #(
    .CNT_W      (CNT_W),
    .LOCK_WIN   (LOCK_WIN),
    .UNLOCK_WIN (UNLOCK_WIN)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .fr    (fr_i),
    .fp    (fp_i),
    .sleep (sleep_i),
    .up    (pump_up_o),
    .dn    (pump_dn_o),
    .done  (done_w),
    .err   (err_w),
    .lock  (held_w),
    .lds   (lds_i),
    .tsel  (tsel_i),
    .mon   (mon_o)
);

// File: tb/sim_pdl_top.sv
module sim_pdl_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] fr = '0, fp = '0, pol = '0, slp = '0, tsel = '0;
    logic       lds = 1'b0;
    logic [1:0] up, dn;
    logic       mon;

    int checks = 0;
    int errors = 0;
    int lk [2];
    int run [2];
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pdl_top u0 (
        .clk(clk), .rst_n(rst_n), .fr_i(fr), .fp_i(fp), .pol_i(pol),
        .sleep_i(slp), .lds_i(lds), .tsel_i(tsel),
        .pump_up_o(up), .pump_dn_o(dn), .mon_o(mon)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_mon();
        return ((lk[0] != 0 || slp[0]) && (lk[1] != 0 || slp[1])) ? 1 : 0;
    endfunction

    task automatic model_cmp(input int ch, input int e);
        if (e >= 8) begin
            lk[ch] = 0; run[ch] = 0;
        end else if (e <= 4) begin
            run[ch]++;
            if (run[ch] >= 3) begin lk[ch] = 1; run[ch] = 3; end
        end else begin
            run[ch] = 0;
        end
    endtask

    // one comparison on channel ch: leader edge, follower edge k cycles later
    task automatic compare(input int ch, input bit fr_first, input int k);
        int eu, ed;
        @(negedge clk);
        if (k == 0) begin
            fr[ch] = 1'b1; fp[ch] = 1'b1;
        end else if (fr_first) fr[ch] = 1'b1;
        else fp[ch] = 1'b1;
        for (int i = 1; i <= k; i++) begin
            @(negedge clk);
            if (i == 1) begin
                if (fr_first) fr[ch] = 1'b0; else fp[ch] = 1'b0;
                eu = (fr_first == pol[ch]) ? 1 : 0;
                ed = 1 - eu;
                if (fr_first) begin
                    check("R1 up", int'(up[ch]), eu);
                    check("R1 dn", int'(dn[ch]), ed);
                end else begin
                    check("R2 up", int'(up[ch]), eu);
                    check("R2 dn", int'(dn[ch]), ed);
                end
            end
            if (i == k) begin
                if (fr_first) fp[ch] = 1'b1; else fr[ch] = 1'b1;
            end
        end
        @(negedge clk);
        fr[ch] = 1'b0; fp[ch] = 1'b0;
        check("R3 align", int'(up[ch] & dn[ch]), 1);
        @(negedge clk);
        check("R3 quiet", int'(up[ch] | dn[ch]), 0);
        model_cmp(ch, k);
        check("R4/R5 lock", int'(mon), exp_mon());
        repeat (2) @(negedge clk);
    endtask

    initial begin
        lk[0] = 0; lk[1] = 0; run[0] = 0; run[1] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 pumps", int'({up, dn}), 0);
        check("R9 mon", int'(mon), 0);

        // power save: quiet pumps, reported locked
        slp = 2'b11;
        @(negedge clk);
        check("R6 mon", int'(mon), 1);
        check("R7 all asleep", int'(mon), 1);
        for (int i = 0; i < 4; i++) begin
            fr = 2'b11;
            @(negedge clk);
            check("R6 quiet", int'({up, dn}), 0);
            fr = 2'b00;
            @(negedge clk);
        end

        // monitor multiplexer, all selects and patterns
        lds = 1'b1;
        for (int t = 0; t < 4; t++) begin
            for (int p = 0; p < 16; p++) begin
                tsel = t[1:0];
                fr = p[1:0];
                fp = p[3:2];
                #1;
                check("R8 mux", int'(mon), t[1] ? int'(p[2 + t[0]]) : int'(p[t[0]]));
            end
        end
        fr = '0; fp = '0; lds = 1'b0; tsel = '0;
        @(negedge clk);

        // per-channel sweep, other channel asleep
        for (int ch = 0; ch < 2; ch++) begin
            slp = (ch == 0) ? 2'b10 : 2'b01;
            lk[0] = 0; lk[1] = 0; run[0] = 0; run[1] = 0;
            @(negedge clk);
            check("R6 wake unlocked", int'(mon), 0);
            for (int pv = 0; pv < 2; pv++) begin
                pol[ch] = pv[0];
                for (int off = -10; off <= 10; off++) begin
                    if (off < 0) compare(ch, 1'b0, -off);
                    else         compare(ch, 1'b1, off);
                end
            end
        end

        // both channels awake: combined flag
        slp = 2'b00;
        lk[0] = 0; run[0] = 0;
        pol = 2'b11;
        @(negedge clk);
        for (int i = 0; i < 3; i++) compare(0, 1'b1, 1);
        for (int i = 0; i < 3; i++) compare(1, 1'b0, 2);
        check("R7 both locked", int'(mon), 1);
        compare(0, 1'b1, 9);
        check("R7 one unlocked", int'(mon), 0);

        // repeated leading edge ignored
        for (int i = 0; i < 3; i++) compare(0, 1'b1, 0);
        check("R10 relocked", int'(mon), 1);
        @(negedge clk);
        fr[0] = 1'b1;
        @(negedge clk);
        fr[0] = 1'b0;
        repeat (4) @(negedge clk);
        fr[0] = 1'b1;
        @(negedge clk);
        fr[0] = 1'b0;
        check("R10 lead held", int'(up[0]), 1);
        repeat (3) @(negedge clk);
        fp[0] = 1'b1;
        @(negedge clk);
        fp[0] = 1'b0;
        @(negedge clk);
        model_cmp(0, 9);
        check("R10 error from first edge", int'(mon), exp_mon());

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule